// File: doc/BRIEF.md
# Three-State Phase-Frequency Comparator

This block is the digital heart of a frequency synthesizer loop. It watches two clocks: a reference derived from a 7.2 MHz crystal, and the local oscillator after the programmable divider. Both are sampled by a fast system clock, and the block keeps a pair of error flags. One flag marks that the divided signal got ahead. The other marks that the reference got ahead. When both flags would be set, both clear. The flag state drives a set of identical charge-pump pins, each modelled as a pad with a drive enable and a drive level. A fast divided signal drives the pins high, a slow one drives them low, and agreement leaves them floating.

A lock indicator counts reference edges in a row that pass without a wide error pulse. Here "wide" means a pulse that lasts two or more system-clock cycles. The analog charge pump, the loop filter and the pad cells are outside the block. Both clock inputs must be synchronous to the system clock and held low during reset.

There is no data stream, so the pins are plain level signals with no handshake.

Top module: `pfd_tristate_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every pin has drive enable 0 and drive level 0, and the lock output is 0.
- R2: A rising edge on the divided input with no reference edge pending sets the fast state from the next cycle. In that state every pin has drive enable 1 and level 1.
- R3: A rising edge on the reference with no divided edge pending sets the slow state from the next cycle. In that state every pin has drive enable 1 and level 0.
- R4: An edge of the opposite input ends a pending fast or slow state on the next cycle. The pins then have drive enable 0 and level 0, which is high impedance.
- R5: Rising edges on both inputs in the same cycle, with nothing pending, leave the pins at high impedance.
- R6: All NUM_PINS pins carry identical enable and level values in every cycle.
- R7: The lock output rises one cycle after the LOCK_REFS-th (default 16) reference rising edge counted since reset or since the last wide pulse.
- R8: If the pins are driven in two consecutive cycles (a wide pulse), the lock output is 0 in the next cycle and the edge count restarts from zero. A wide pulse in the same cycle as a reference edge means that edge is not counted.
- R9: Error pulses of exactly one cycle do not stop the edge count or clear lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, synchronous to clk |
| fb_clk_i | input | 1 | Divided oscillator clock, synchronous to clk |
| pad_oe_o | output | NUM_PINS | Per-pin drive enable; 0 means floating |
| pad_lvl_o | output | NUM_PINS | Per-pin driven level, 0 when floating |
| lock_o | output | 1 | Lock indicator |

## Verification
The comparator is driven with a divided clock that is faster than the reference, slower than it, and at the same rate. This separates sustained high drive, sustained low drive and floating output. At the same rate, three phase offsets are used. Zero offset gives coincident edges and must never drive the pins. A one-cycle offset gives narrow pulses, which must still reach lock. A four-cycle offset gives wide pulses, which must hold lock low. Every cycle is compared against a behavioural model, so the exact cycle of each pin change and of the lock rise is checked. Going from the wide-pulse pattern back to zero offset shows that lock takes the full count again.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PAD_FLOAT = 2'd0,
    PAD_HIGH  = 2'd1,
    PAD_LOW   = 2'd2
  } pad_state_e;
endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_d <= 1'b0;
    else        sig_d <= sig_i;
  end

  assign rise_o = sig_i & ~sig_d;
endmodule

// File: rtl/pfd_flag_pair.sv
module pfd_flag_pair
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_rise_i,
  input  logic       ref_rise_i,
  output logic       fast_o,
  output logic       slow_o,
  output pad_state_e state_o
);
  logic fast_q, slow_q;
  logic fast_set, slow_set, cancel;

  assign fast_set = fast_q | fb_rise_i;
  assign slow_set = slow_q | ref_rise_i;
  assign cancel   = fast_set & slow_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      fast_q <= fast_set & ~cancel;
      slow_q <= slow_set & ~cancel;
    end
  end

  always_comb begin
    state_o = PAD_FLOAT;
    if (fast_q)      state_o = PAD_HIGH;
    else if (slow_q) state_o = PAD_LOW;
  end

  assign fast_o = fast_q;
  assign slow_o = slow_q;
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_REFS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise_i,
  input  logic err_i,
  output logic lock_o
);
  localparam int CNT_W = $clog2(LOCK_REFS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_REFS);

  logic [CNT_W-1:0] cnt_q;
  logic             err_d;
  logic             wide;

  assign wide = err_i & err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_d <= 1'b0;
    end else begin
      err_d <= err_i;
      if (wide)
        cnt_q <= '0;
      else if (ref_rise_i && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pfd_tristate_cmp.sv
module pfd_tristate_cmp
  import pfd_pkg::*;
#(
  parameter int NUM_PINS  = 2,
  parameter int LOCK_REFS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_clk_i,
  input  logic                fb_clk_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_lvl_o,
  output logic                lock_o
);
  logic       ref_rise, fb_rise;
  logic       fast, slow;
  pad_state_e pad_state;

  pfd_rise_det u_ref_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(ref_clk_i), .rise_o(ref_rise)
  );

  pfd_rise_det u_fb_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(fb_clk_i), .rise_o(fb_rise)
  );

  pfd_flag_pair u_flags (
    .clk(clk), .rst_n(rst_n),
    .fb_rise_i(fb_rise), .ref_rise_i(ref_rise),
    .fast_o(fast), .slow_o(slow), .state_o(pad_state)
  );

  pfd_lock_det #(.LOCK_REFS(LOCK_REFS)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .ref_rise_i(ref_rise), .err_i(fast | slow),
    .lock_o(lock_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_oe_o[p]  = (pad_state != PAD_FLOAT);
    assign pad_lvl_o[p] = (pad_state == PAD_HIGH);
  end
endmodule

// File: rtl/pfd_tristate_cmp_chk.sv
module pfd_tristate_cmp_chk #(
  parameter int NUM_PINS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_clk_i,
  input logic                fb_clk_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_lvl_o,
  input logic                lock_o
);
  logic drv_hi, drv_lo;
  assign drv_hi = pad_oe_o[0] & pad_lvl_o[0];
  assign drv_lo = pad_oe_o[0] & ~pad_lvl_o[0];

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (pad_oe_o == '0 && pad_lvl_o == '0 && !lock_o);
    end
  end

  // R6
  pins_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe_o == {NUM_PINS{pad_oe_o[0]}} && pad_lvl_o == {NUM_PINS{pad_lvl_o[0]}});

  // R2
  high_after_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(fb_clk_i));

  // R3
  low_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> $past(ref_clk_i));

  // R7
  lock_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_clk_i));

  // R8
  wide_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o[0] && $past(pad_oe_o[0])) |=> !lock_o);

  // R4
  float_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe_o[0] |-> !pad_lvl_o[0]);
endmodule

bind pfd_tristate_cmp pfd_tristate_cmp_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i), .fb_clk_i(fb_clk_i),
  .pad_oe_o(pad_oe_o), .pad_lvl_o(pad_lvl_o), .lock_o(lock_o)
);

// File: tb/test_pfd_tristate_cmp.sv
module test_pfd_tristate_cmp;
  localparam int NP   = 2;
  localparam int LOCK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0;
  logic [NP-1:0] oe, lvl;
  logic lock;

  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pfd_tristate_cmp #(.NUM_PINS(NP), .LOCK_REFS(LOCK)) i_pfd_tristate_cmp (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_i), .fb_clk_i(fb_i),
    .pad_oe_o(oe), .pad_lvl_o(lvl), .lock_o(lock)
  );

  // behavioural reference model
  bit m_ref_d, m_fb_d, m_fast, m_slow, m_err_d;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ref_d = 0; m_fb_d = 0; m_fast = 0; m_slow = 0; m_err_d = 0; m_cnt = 0;
    end else begin
      bit re, fe, nf, ns, wide;
      re = ref_i && !m_ref_d;
      fe = fb_i && !m_fb_d;
      wide = (m_fast || m_slow) && m_err_d;
      if (wide) m_cnt = 0;
      else if (re && m_cnt < LOCK) m_cnt++;
      m_err_d = m_fast || m_slow;
      nf = m_fast || fe;
      ns = m_slow || re;
      if (nf && ns) begin m_fast = 0; m_slow = 0; end
      else begin m_fast = nf; m_slow = ns; end
      m_ref_d = ref_i;
      m_fb_d = fb_i;
    end
  end

  task automatic compare(string req);
    bit exp_oe, exp_lvl, exp_lock;
    exp_oe = m_fast || m_slow;
    exp_lvl = m_fast;
    exp_lock = (m_cnt == LOCK);
    n_vec++;
    if (oe !== {NP{exp_oe}} || lvl !== {NP{exp_lvl}} || lock !== exp_lock) begin
      n_bad++;
      $display("FAIL %s cyc %0d: oe=%b lvl=%b lock=%b expected oe=%b lvl=%b lock=%b",
               req, cyc, oe, lvl, lock, {NP{exp_oe}}, {NP{exp_lvl}}, exp_lock);
    end
    // R6: all pins identical
    n_vec++;
    if (oe !== {NP{oe[0]}} || lvl !== {NP{lvl[0]}}) begin
      n_bad++;
      $display("FAIL R6 cyc %0d: oe=%b lvl=%b expected all pins equal", cyc, oe, lvl);
    end
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic run(int n, int rp, int fp, int ph, string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      ref_i = ((cyc % rp) < rp / 2);
      fb_i  = (((cyc + fp - ph) % fp) < fp / 2);
      cyc++;
    end
  endtask

  int hi_seen, lo_seen;
  always @(negedge clk) if (rst_n) begin
    if (oe[0] && lvl[0]) hi_seen++;
    if (oe[0] && !lvl[0]) lo_seen++;
  end

  initial begin
    hi_seen = 0; lo_seen = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    expect_bit("R1", lock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    expect_bit("R1", oe[0], 1'b0);

    // R5/R7: coincident edges, never driven, lock after 16 ref edges
    hi_seen = 0; lo_seen = 0;
    run(20 * 17 + 4, 20, 20, 0, "R7");
    expect_bit("R5", (hi_seen + lo_seen) != 0, 1'b0);
    expect_bit("R7", lock, 1'b1);

    // R8: four-cycle lead gives wide pulses, lock lost
    run(200, 20, 20, 4, "R8");
    expect_bit("R8", lock, 1'b0);

    // R9: one-cycle lead pulses still reach lock
    run(20 * 17 + 4, 20, 20, 1, "R9");
    expect_bit("R9", lock, 1'b1);

    // R2: divided clock faster than reference
    hi_seen = 0;
    run(400, 20, 12, 0, "R2");
    expect_bit("R2", hi_seen > 0, 1'b1);

    // R3: divided clock slower than reference
    lo_seen = 0;
    run(400, 12, 20, 0, "R3");
    expect_bit("R3", lo_seen > 0, 1'b1);

    // R4: equal rate with offset, pulses end and pins float
    run(200, 20, 20, 3, "R4");
    expect_bit("R4", oe[0] == 1'b0 || lvl[0] == 1'b1, 1'b1);

    // relock after return to zero offset
    run(20 * 17 + 4, 20, 20, 0, "R7");
    expect_bit("R7", lock, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule